// File: doc/BRIEF.md
# Iterative Signed-Digit Fraction Divider

This block divides one normalized 24-bit fraction by another with a radix-2 SRT recurrence. It retires one quotient digit per clock. Each step doubles the partial remainder and picks a digit from {-1, 0, +1} by looking only at the top three bits of the doubled remainder. One shared adder/subtractor then subtracts the divisor, adds it, or passes the doubled remainder through. The signed digits are turned into a plain binary quotient as they arrive, using two shadow registers. There is no carry-propagate conversion at the end.

A controller pulses `init` for one clock with the operands present. The first recurrence step runs in that same clock. The quotient appears, together with a one-clock `done` pulse, 24 rising edges after it, counting the edge that sampled `init`. Both operands are fixed-point fractions: bit i carries the weight 2^(i-24). The dividend must lie in [0.25, 0.5), so its top two bits are 01. The divisor must lie in [0.5, 1), so its top bit is 1. With operands in these ranges the quotient lies in [0.25, 1), in the same 24-bit fraction format. If the final remainder comes out negative, the quotient is corrected down by one unit in the last place. The result is therefore the truncated quotient.

Top module: `srt_frac_div`

## Requirements
- R1: While reset is high and after it is released, `done` is 0 and `quotient` is 0 until the first operation completes.
- R2: For a dividend x in [0.25, 0.5) (bits [23:22] = 01) and a divisor d in [0.5, 1) (bit 23 = 1), the result is floor(x * 2^24 / d), read as 24-bit integers.
- R3: `done` is high for exactly one clock. It rises after the 24th rising edge, counting the edge that sampled `init` as the first.
- R4: `quotient` changes only on the edge that raises `done`, and it holds its value in every other cycle.
- R5: If `init` is held high for several cycles, the first step is repeated and nothing advances. The operation counts from the last edge at which `init` was high.
- R6: An `init` during a running operation abandons that operation without a `done` and restarts with the operands now presented.
- R7: Both operands are captured on the `init` edge. Later changes on `dividend` or `divisor` have no effect on the result.
- R8: The partial remainder stays within [-d, d) throughout an operation, including when d = 0.5 and the remainder settles at -d.
- R9: When the final partial remainder is negative, the output is the lower on-the-fly copy of the quotient. Exact divisions therefore yield the exact quotient, for example 0x400000 / 0x800000 = 0x800000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| init | input | 1 | Start pulse; the first step runs in this cycle |
| dividend | input | 24 | Dividend fraction in [0.25, 0.5) |
| divisor | input | 24 | Divisor fraction in [0.5, 1) |
| quotient | output | 24 | Registered truncated quotient fraction |
| done | output | 1 | One-clock pulse when `quotient` is updated |

## Verification
The assertions take for granted that every `init` carries a dividend with top bits 01 and a divisor with its top bit set. The remainder bound and the check that the quotient falls in [0.25, 1) hold only under that premise. The random stimulus builds each operand from fixed leading bits followed by random low bits, so it never leaves these ranges. Between `init` pulses the bench writes arbitrary values onto the operand pins, so the capture rule is exercised without breaking the premise.

// File: rtl/srt_div_pkg.sv
package srt_div_pkg;
  // signed quotient digit, two's complement coded
  typedef enum logic [1:0] {
    DIG_ZERO = 2'b00,
    DIG_POS  = 2'b01,
    DIG_NEG  = 2'b11
  } digit_t;
endpackage

// File: rtl/srt_digit_sel.sv
module srt_digit_sel
  import srt_div_pkg::*;
#(
  parameter int RW = 26
) (
  input  logic [RW-1:0] two_r,
  output digit_t        dig
);
  // top three bits: sign, integer, half; value in units of 0.5, floored
  logic signed [2:0] est;

  always_comb begin
    est = $signed(two_r[RW-1:RW-3]);
    if (est >= 3'sd1)       dig = DIG_POS;
    else if (est <= -3'sd2) dig = DIG_NEG;
    else                    dig = DIG_ZERO;
  end
endmodule

// File: rtl/srt_addsub.sv
module srt_addsub
  import srt_div_pkg::*;
#(
  parameter int RW = 26
) (
  input  logic [RW-1:0] a,
  input  logic [RW-1:0] dvs,
  input  digit_t        dig,
  output logic [RW-1:0] sum
);
  logic [RW-1:0] opnd;
  logic          cin;

  // operand select: -d (invert plus carry), +d, or zero
  always_comb begin
    unique case (dig)
      DIG_POS: begin opnd = ~dvs;      cin = 1'b1; end
      DIG_NEG: begin opnd = dvs;       cin = 1'b0; end
      default: begin opnd = '0;        cin = 1'b0; end
    endcase
    sum = a + opnd + {{(RW-1){1'b0}}, cin};
  end
endmodule

// File: rtl/srt_otf_conv.sv
module srt_otf_conv
  import srt_div_pkg::*;
#(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         step,
  input  digit_t       dig,
  output logic [W-1:0] q_nxt,
  output logic [W-1:0] qm_nxt
);
  logic [W-1:0] q_r, qm_r, q_base, qm_base;

  // a new operation starts from Q = 0 and QM = -ulp
  assign q_base  = load ? '0 : q_r;
  assign qm_base = load ? '1 : qm_r;

  always_comb begin
    unique case (dig)
      DIG_POS: begin
        q_nxt  = {q_base[W-2:0], 1'b1};
        qm_nxt = {q_base[W-2:0], 1'b0};
      end
      DIG_NEG: begin
        q_nxt  = {qm_base[W-2:0], 1'b1};
        qm_nxt = {qm_base[W-2:0], 1'b0};
      end
      default: begin
        q_nxt  = {q_base[W-2:0], 1'b0};
        qm_nxt = {qm_base[W-2:0], 1'b1};
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_r  <= '0;
      qm_r <= '0;
    end else if (load || step) begin
      q_r  <= q_nxt;
      qm_r <= qm_nxt;
    end
  end
endmodule

// File: rtl/srt_frac_div.sv
module srt_frac_div
  import srt_div_pkg::*;
#(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         init,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quotient,
  output logic         done
);
  localparam int RW = W + 2;
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] LAST_CNT = CW'(W - 1);

  logic [RW-1:0] rem_r, part, two_r, rem_nxt;
  logic [W-1:0]  dvs_r, dvs_use, q_nxt, qm_nxt, quo_r;
  logic [CW-1:0] cnt_r;
  logic          busy_r, done_r, last;
  digit_t        dig;

  // 2:1 select: fresh dividend on init, otherwise the held remainder
  assign part    = init ? {2'b00, dividend} : rem_r;
  assign two_r   = {part[RW-2:0], 1'b0};
  assign dvs_use = init ? divisor : dvs_r;
  assign last    = busy_r && !init && (cnt_r == LAST_CNT);

  srt_digit_sel #(.RW(RW)) u_sel (
    .two_r (two_r),
    .dig   (dig)
  );

  srt_addsub #(.RW(RW)) u_add (
    .a   (two_r),
    .dvs ({2'b00, dvs_use}),
    .dig (dig),
    .sum (rem_nxt)
  );

  srt_otf_conv #(.W(W)) u_otf (
    .clk    (clk),
    .rst    (rst),
    .load   (init),
    .step   (busy_r),
    .dig    (dig),
    .q_nxt  (q_nxt),
    .qm_nxt (qm_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_r  <= '0;
      dvs_r  <= '0;
      cnt_r  <= '0;
      busy_r <= 1'b0;
      done_r <= 1'b0;
      quo_r  <= '0;
    end else begin
      done_r <= 1'b0;
      if (init) begin
        rem_r  <= rem_nxt;
        dvs_r  <= divisor;
        cnt_r  <= CW'(1);
        busy_r <= 1'b1;
      end else if (busy_r) begin
        rem_r <= rem_nxt;
        cnt_r <= cnt_r + CW'(1);
        if (last) begin
          busy_r <= 1'b0;
          done_r <= 1'b1;
          // negative final remainder: take the lower copy
          quo_r  <= rem_nxt[RW-1] ? qm_nxt : q_nxt;
        end
      end
    end
  end

  assign quotient = quo_r;
  assign done     = done_r;
endmodule

// File: rtl/srt_frac_div_chk.sv
module srt_frac_div_chk #(
  parameter int W  = 24,
  parameter int RW = 26
) (
  input logic          clk,
  input logic          rst,
  input logic          init,
  input logic          done,
  input logic [W-1:0]  quotient,
  input logic          busy,
  input logic [RW-1:0] rem,
  input logic [W-1:0]  dvs
);
  localparam int SW = $clog2(W + 2) + 1;
  localparam logic [SW-1:0] SMAX = '1;

  logic [SW-1:0]        since;
  logic signed [RW-1:0] rem_s, hi_s, lo_s;

  assign rem_s = $signed(rem);
  assign hi_s  = $signed({2'b00, dvs});
  assign lo_s  = -hi_s;

  // edges elapsed since the last init edge, saturating
  always_ff @(posedge clk) begin
    if (rst)               since <= SMAX;
    else if (init)         since <= '0;
    else if (since != SMAX) since <= since + SW'(1);
  end

  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_latency_R3: assert property (@(posedge clk) disable iff (rst)
    done |-> (since == SW'(W - 1)));

  assert_quotient_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(quotient));

  assert_start_busy_R5: assert property (@(posedge clk) disable iff (rst)
    init |=> busy);

  assert_rem_bound_R8: assert property (@(posedge clk) disable iff (rst)
    busy |-> ((rem_s < hi_s) && (rem_s >= lo_s)));

  assert_quotient_range_R2: assert property (@(posedge clk) disable iff (rst)
    done |-> (quotient[W-1:W-2] != 2'b00));
endmodule

bind srt_frac_div srt_frac_div_chk #(.W(W), .RW(RW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .init     (init),
  .done     (done),
  .quotient (quotient),
  .busy     (busy_r),
  .rem      (rem_r),
  .dvs      (dvs_r)
);

// File: tb/srt_frac_div_bench.sv
module srt_frac_div_bench;
  localparam int W          = 24;
  localparam int CLK_PERIOD = 10;
  localparam int SEED       = 1234;
  localparam int LATENCY    = 24;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         init = 1'b0;
  logic [W-1:0] dividend = '0;
  logic [W-1:0] divisor = '0;
  logic [W-1:0] quotient;
  logic         done;

  int total = 0;
  int bad   = 0;

  srt_frac_div #(.W(W)) u_srt_frac_div (
    .clk      (clk),
    .rst      (rst),
    .init     (init),
    .dividend (dividend),
    .divisor  (divisor),
    .quotient (quotient),
    .done     (done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [W-1:0] ref_q(input logic [W-1:0] x, input logic [W-1:0] d);
    logic [2*W-1:0] n;
    n = {x, {W{1'b0}}};
    return W'(n / {{W{1'b0}}, d});
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // waits for done after the init edge; returns edges counted from it
  task automatic wait_done(output int edges);
    edges = 1;
    while (!done && edges < 100) begin
      @(posedge clk);
      @(negedge clk);
      // R7: disturb operand pins while running
      dividend = W'($urandom);
      divisor  = W'($urandom);
      edges++;
    end
  endtask

  task automatic run_div(input logic [W-1:0] x, input logic [W-1:0] d,
                         input int hold, input string req);
    int edges;
    logic [W-1:0] got;
    dividend = x;
    divisor  = d;
    init     = 1'b1;
    for (int k = 0; k < hold; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
    init = 1'b0;
    wait_done(edges);
    chk("R3 latency", W'(edges), W'(LATENCY));
    chk(req, quotient, ref_q(x, d));
    got = quotient;
    @(posedge clk);
    @(negedge clk);
    chk("R3 done pulse", W'(done), '0);
    chk("R4 hold", quotient, got);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int dummy;
    dummy = $urandom(SEED);
    repeat (3) @(negedge clk);
    chk("R1 reset done", W'(done), '0);
    chk("R1 reset quotient", quotient, '0);
    rst = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R1 idle done", W'(done), '0);
    chk("R1 idle quotient", quotient, '0);

    // directed corners
    run_div(24'h400000, 24'hFFFFFF, 1, "R2 min over max");
    run_div(24'h7FFFFF, 24'h800000, 1, "R2 near one");
    run_div(24'h400000, 24'h800000, 1, "R9 exact half");
    run_div(24'h600000, 24'hC00000, 1, "R9 exact 0.75");
    run_div(24'h555555, 24'hAAAAAA, 1, "R9 exact thirds");
    run_div(24'h4AAAAA, 24'h800000, 1, "R8 divisor 0.5");
    run_div(24'h7FFFFF, 24'hFFFFFF, 1, "R2 max over max");

    // R5: init held high for several cycles
    run_div(24'h5A5A5A, 24'hC3C3C3, 4, "R5 held init");

    // R6: restart during operation, no done from the abandoned one
    begin
      int seen;
      seen = 0;
      dividend = 24'h7ABCDE;
      divisor  = 24'h812345;
      init     = 1'b1;
      @(posedge clk);
      @(negedge clk);
      init = 1'b0;
      for (int k = 0; k < 10; k++) begin
        @(posedge clk);
        @(negedge clk);
        if (done) seen++;
      end
      chk("R6 no early done", W'(seen), '0);
      run_div(24'h4F0F0F, 24'hE1E1E1, 1, "R6 restart result");
    end

    // constrained random operands
    for (int i = 0; i < 300; i++) begin
      logic [W-1:0] x, d;
      x = {2'b01, W'($urandom) >> 2};
      x[W-1:W-2] = 2'b01;
      d = W'($urandom);
      d[W-1] = 1'b1;
      run_div(x, d, 1, "R2 random R7");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule